// File: doc/BRIEF.md
# Offset Trim Calibration Sequencer

This block finds the offset trim code for one analog output channel without software in the loop. After a start strobe it takes the channel out of normal service and applies candidate trim codes to the analog side. After each candidate it waits a programmable settle interval and then samples a one-bit comparator flag. A high flag means the code is at or above the ideal point and the search moves down. A low flag moves it up. The step starts at a quarter of the code range and halves after every decision. One more settled sample then decides whether the result needs to move up by a single code.

While the sequence runs, the block overrides the channel's output enable, data word and output mode. The output enable is forced off, the data word is forced to mid-scale, and the mode is forced to zero. The mode that was in use when the start was accepted is held internally and comes back when the sequence ends. The trim register can also be written directly by the user at any time. The trim output always shows the code currently applied, so it also serves as the readback.

Top module: `trim_cal_ctrl`

## Requirements
- R1: After reset, busy_o, done_o, err_o and cal_en_o are 0, trim_o is 16 (mid-code), and mode_o is 0.
- R2: A start_i sampled while busy_o is 0 is accepted. From the next cycle, busy_o and cal_en_o are 1 and trim_o is 16. The first search step is 8.
- R3: Each candidate stays on trim_o for exactly SETTLE_CYC cycles. At the end of that window cmp_flag_i is sampled. If the flag is 1, the step is subtracted from the trim; if it is 0, the step is added. The step then halves, so the search uses steps 8, 4, 2 and 1 and the trim code wraps modulo 32.
- R4: After the step of 1, the final candidate is held for another SETTLE_CYC cycles. If cmp_flag_i is then 0, the trim is incremented by one, saturating at 31. With a comparator that is high for trim >= T, the result is T for T in 1..31, 1 for T = 0, and 31 for T = 32.
- R5: done_o is high for exactly one cycle after the final decision. In that cycle busy_o is still 1 and cal_en_o is 0. In the next cycle busy_o is 0. An accepted start keeps busy_o high for 5*SETTLE_CYC+1 cycles.
- R6: While busy_o is 1, out_en_o is 0 and data_o is 0x800 (mid-scale of 12 bits). While busy_o is 0, out_en_o and data_o pass out_en_cfg_i and data_cfg_i through in the same cycle.
- R7: While idle, mode_o shows the value mode_cfg_i had one cycle earlier. mode_o is 0 while busy_o is 1. The mode held at the accepted start is restored in the first idle cycle, whatever mode_cfg_i did during the sequence.
- R8: A start_i sampled while busy_o is 1 is ignored and leaves the sequence unchanged. It sets err_o from the next cycle. err_o stays 1 until the next accepted start clears it.
- R9: usr_wr_i loads usr_trim_i onto trim_o in the next cycle, both idle and during a sequence. In the same cycle it takes precedence over a search or final update. A sequence in progress continues from the written code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Calibration start strobe |
| cmp_flag_i | input | 1 | Comparator flag from the analog side |
| usr_wr_i | input | 1 | Direct trim write strobe |
| usr_trim_i | input | TRIM_W | Trim value for a direct write |
| out_en_cfg_i | input | 1 | Normal output enable of the channel |
| mode_cfg_i | input | MODE_W | Normal output mode of the channel |
| data_cfg_i | input | DATA_W | Normal data word of the channel |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| err_o | output | 1 | Sticky refused-start indication |
| cal_en_o | output | 1 | Calibration enable to the analog side |
| trim_o | output | TRIM_W | Applied trim code and readback |
| out_en_o | output | 1 | Channel output enable after override |
| mode_o | output | MODE_W | Channel output mode after override |
| data_o | output | DATA_W | Channel data word after override |

## Verification
The in-line assertions check properties that hold on every cycle:

- the done pulse lasts one cycle and falls inside busy with the calibration enable low;
- a refused start sets and holds the error flag;
- a direct write wins over the search;
- the step stays a single bit during the search;
- the settle counter stays within its limit;
- the held mode is frozen while busy;
- the final increment never wraps past the top code.

The bench's scenarios with chosen comparator thresholds are what show that the search converges on the right code, including both clamped ends. The scenarios also show the settle-window timing, the restore of a mode changed mid-sequence, and how a write during the search redirects the result.

// File: rtl/trim_cal_pkg.sv
package trim_cal_pkg;
  typedef enum logic [1:0] {
    CAL_IDLE   = 2'd0,
    CAL_SEARCH = 2'd1,
    CAL_FINAL  = 2'd2,
    CAL_DONE   = 2'd3
  } cal_state_e;
endpackage

// File: rtl/trim_cal_timer.sv
module trim_cal_timer #(
  parameter int SETTLE_CYC = 48000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic tick_o
);
  localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CNT_W-1:0] LIM = CNT_W'(SETTLE_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_n;

  assign tick_o = en_i && (cnt_q == LIM);

  always_comb begin
    cnt_n = cnt_q;
    if (!en_i || tick_o) cnt_n = '0;
    else                 cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  // R3: the settle counter never passes its window
  a_r3_settle_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM);
endmodule

// File: rtl/trim_cal_seq.sv
module trim_cal_seq
  import trim_cal_pkg::*;
#(
  parameter int TRIM_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              flag_i,
  input  logic              tick_i,
  input  logic              usr_wr_i,
  input  logic [TRIM_W-1:0] usr_trim_i,
  output cal_state_e        state_o,
  output logic [TRIM_W-1:0] trim_o,
  output logic              err_o
);
  localparam logic [TRIM_W-1:0] TRIM_MID = TRIM_W'(1) << (TRIM_W - 1);
  localparam logic [TRIM_W-1:0] STEP0    = TRIM_W'(1) << (TRIM_W - 2);
  localparam logic [TRIM_W-1:0] TRIM_MAX = '1;

  cal_state_e        state_q, state_n;
  logic [TRIM_W-1:0] trim_q, trim_n;
  logic [TRIM_W-1:0] step_q, step_n;
  logic              err_q, err_n;
  logic              step_en;

  always_comb begin
    state_n = state_q;
    trim_n  = trim_q;
    step_n  = step_q;
    err_n   = err_q;
    if (start_i) err_n = (state_q != CAL_IDLE);
    unique case (state_q)
      CAL_IDLE: begin
        if (start_i) begin
          state_n = CAL_SEARCH;
          trim_n  = TRIM_MID;
          step_n  = STEP0;
        end
      end
      CAL_SEARCH: begin
        if (tick_i) begin
          trim_n = flag_i ? (trim_q - step_q) : (trim_q + step_q);
          step_n = step_q >> 1;
          if (step_q == TRIM_W'(1)) state_n = CAL_FINAL;
        end
      end
      CAL_FINAL: begin
        if (tick_i) begin
          if (!flag_i && (trim_q != TRIM_MAX)) trim_n = trim_q + 1'b1;
          state_n = CAL_DONE;
        end
      end
      CAL_DONE: state_n = CAL_IDLE;
      default:  state_n = CAL_IDLE;
    endcase
    if (usr_wr_i) trim_n = usr_trim_i;
  end

  assign step_en = (state_q == CAL_IDLE) || tick_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CAL_IDLE;
      trim_q  <= TRIM_MID;
      step_q  <= STEP0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      trim_q  <= trim_n;
      err_q   <= err_n;
      if (step_en) step_q <= step_n;
    end
  end

  assign state_o = state_q;
  assign trim_o  = trim_q;
  assign err_o   = err_q;

  // R3: the search step is always a single power of two
  a_r3_step_single: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CAL_SEARCH) |-> ($countones(step_q) == 1));
  // R4: the final increment saturates at the top code
  a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CAL_FINAL && tick_i && !usr_wr_i && trim_q == TRIM_MAX) |=> (trim_q == TRIM_MAX));
  // R5: the end state lasts one cycle
  a_r5_done_once: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CAL_DONE) |=> (state_q == CAL_IDLE));
  // R8: a start during a sequence raises the error flag
  a_r8_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && state_q != CAL_IDLE) |=> err_q);
  // R8: the error flag holds until an accepted start
  a_r8_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !(start_i && state_q == CAL_IDLE)) |=> err_q);
  // R9: a direct write always lands
  a_r9_user_wins: assert property (@(posedge clk) disable iff (!rst_n)
    usr_wr_i |=> (trim_q == $past(usr_trim_i)));
endmodule

// File: rtl/trim_cal_ovr.sv
module trim_cal_ovr #(
  parameter int DATA_W = 12,
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic              out_en_cfg_i,
  input  logic [MODE_W-1:0] mode_cfg_i,
  input  logic [DATA_W-1:0] data_cfg_i,
  output logic              out_en_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [DATA_W-1:0] data_o
);
  localparam logic [DATA_W-1:0] DATA_MID = DATA_W'(1) << (DATA_W - 1);

  logic [MODE_W-1:0] mode_q;
  logic              mode_en;

  assign mode_en = !busy_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_en) mode_q <= mode_cfg_i;
  end

  assign out_en_o = busy_i ? 1'b0     : out_en_cfg_i;
  assign data_o   = busy_i ? DATA_MID : data_cfg_i;
  assign mode_o   = busy_i ? '0       : mode_q;

  // R7: the saved mode is frozen for the whole sequence
  a_r7_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> (mode_q == $past(mode_q)));
endmodule

// File: rtl/trim_cal_ctrl.sv
module trim_cal_ctrl
  import trim_cal_pkg::*;
#(
  parameter int TRIM_W     = 5,
  parameter int DATA_W     = 12,
  parameter int MODE_W     = 3,
  parameter int SETTLE_CYC = 48000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              cmp_flag_i,
  input  logic              usr_wr_i,
  input  logic [TRIM_W-1:0] usr_trim_i,
  input  logic              out_en_cfg_i,
  input  logic [MODE_W-1:0] mode_cfg_i,
  input  logic [DATA_W-1:0] data_cfg_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              cal_en_o,
  output logic [TRIM_W-1:0] trim_o,
  output logic              out_en_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [DATA_W-1:0] data_o
);
  localparam logic [TRIM_W-1:0] TRIM_MID = TRIM_W'(1) << (TRIM_W - 1);

  cal_state_e state;
  logic       tick;

  trim_cal_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (cal_en_o),
    .tick_o (tick)
  );

  trim_cal_seq #(.TRIM_W(TRIM_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .flag_i     (cmp_flag_i),
    .tick_i     (tick),
    .usr_wr_i   (usr_wr_i),
    .usr_trim_i (usr_trim_i),
    .state_o    (state),
    .trim_o     (trim_o),
    .err_o      (err_o)
  );

  assign busy_o   = (state != CAL_IDLE);
  assign done_o   = (state == CAL_DONE);
  assign cal_en_o = (state == CAL_SEARCH) || (state == CAL_FINAL);

  trim_cal_ovr #(.DATA_W(DATA_W), .MODE_W(MODE_W)) u_ovr (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy_i       (busy_o),
    .out_en_cfg_i (out_en_cfg_i),
    .mode_cfg_i   (mode_cfg_i),
    .data_cfg_i   (data_cfg_i),
    .out_en_o     (out_en_o),
    .mode_o       (mode_o),
    .data_o       (data_o)
  );

  // R5: done falls inside busy with the calibration enable dropped
  a_r5_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (busy_o && !cal_en_o));
  // R5: done is a single-cycle pulse
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R2: an accepted start enters the search at mid-code
  a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && !usr_wr_i) |=> (busy_o && cal_en_o && trim_o == TRIM_MID));
endmodule

// File: tb/trim_cal_ctrl_bench.sv
module trim_cal_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 3;
  localparam int TW = 5, DW = 12, MW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, usr_wr = 1'b0, out_en_cfg = 1'b0;
  logic [TW-1:0] usr_trim = '0;
  logic [MW-1:0] mode_cfg = '0;
  logic [DW-1:0] data_cfg = '0;
  logic busy, done, err, cal_en, out_en, cmp;
  logic [TW-1:0] trim;
  logic [MW-1:0] mode;
  logic [DW-1:0] data;
  int thr = 16;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign cmp = (int'(trim) >= thr);

  trim_cal_ctrl #(.TRIM_W(TW), .DATA_W(DW), .MODE_W(MW), .SETTLE_CYC(SETTLE)) u_trim_cal_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cmp_flag_i(cmp), .usr_wr_i(usr_wr),
    .usr_trim_i(usr_trim), .out_en_cfg_i(out_en_cfg), .mode_cfg_i(mode_cfg), .data_cfg_i(data_cfg),
    .busy_o(busy), .done_o(done), .err_o(err), .cal_en_o(cal_en), .trim_o(trim),
    .out_en_o(out_en), .mode_o(mode), .data_o(data));

  task automatic chk(input int act, input int exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 search, 2 final, 3 end
  int m_ph = 0, m_trim = 16, m_step = 8, m_wait = 0, m_err = 0, m_mode = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_trim = 16; m_step = 8; m_wait = 0; m_err = 0; m_mode = 0;
    end else begin
      int ph;
      ph = m_ph;
      if (ph == 0) m_mode = int'(mode_cfg);
      if (start) m_err = (ph != 0) ? 1 : 0;
      if (ph == 0) begin
        if (start) begin m_ph = 1; m_trim = 16; m_step = 8; m_wait = 0; end
      end else if (ph == 1) begin
        if (m_wait == SETTLE - 1) begin
          if (m_trim >= thr) m_trim = (m_trim - m_step + 32) % 32;
          else               m_trim = (m_trim + m_step) % 32;
          if (m_step == 1) m_ph = 2;
          m_step = m_step / 2;
          m_wait = 0;
        end else m_wait++;
      end else if (ph == 2) begin
        if (m_wait == SETTLE - 1) begin
          if (m_trim < thr && m_trim != 31) m_trim++;
          m_ph = 3; m_wait = 0;
        end else m_wait++;
      end else m_ph = 0;
      if (usr_wr) m_trim = int'(usr_trim);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit mb;
      mb = (m_ph != 0);
      chk(int'(busy), int'(mb), "R2 busy");
      chk(int'(done), int'(m_ph == 3), "R5 done");
      chk(int'(cal_en), int'(m_ph == 1 || m_ph == 2), "R5 cal_en");
      chk(int'(trim), m_trim, "R3 trim");
      chk(int'(err), m_err, "R8 err");
      chk(int'(mode), mb ? 0 : m_mode, "R7 mode");
      chk(int'(out_en), mb ? 0 : int'(out_en_cfg), "R6 out_en");
      chk(int'(data), mb ? 'h800 : int'(data_cfg), "R6 data");
    end
  end

  task automatic wait_done();
    for (int i = 0; i < 200 && !done; i++) @(negedge clk);
  endtask

  task automatic run_cal(input int t, input int exp_trim);
    int cyc;
    thr = t;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 1;
    while (!done && cyc < 200) begin @(negedge clk); cyc++; end
    chk(int'(trim), exp_trim, "R4 final trim");
    chk(cyc, 5*SETTLE + 1, "R5 busy length");
    @(negedge clk);
    chk(int'(busy), 0, "R5 busy drop");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(int'(busy), 0, "R1 busy"); chk(int'(done), 0, "R1 done");
    chk(int'(err), 0, "R1 err"); chk(int'(cal_en), 0, "R1 cal_en");
    chk(int'(trim), 16, "R1 trim"); chk(int'(mode), 0, "R1 mode");
    rst_n = 1'b1;
    out_en_cfg = 1'b1; data_cfg = 12'h3A5; mode_cfg = 3'd5;
    @(negedge clk);
    chk(int'(data), 'h3A5, "R6 idle data"); chk(int'(out_en), 1, "R6 idle out_en");
    @(negedge clk);
    chk(int'(mode), 5, "R7 idle mode");

    run_cal(17, 17);
    run_cal(16, 16);
    run_cal(1, 1);
    run_cal(0, 1);
    run_cal(31, 31);
    run_cal(32, 31);
    run_cal(9, 9);

    // mode restore and override while busy
    thr = 20; mode_cfg = 3'd5;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; mode_cfg = 3'd2;
    chk(int'(mode), 0, "R7 mode forced");
    chk(int'(data), 'h800, "R6 mid data"); chk(int'(out_en), 0, "R6 out_en off");
    wait_done();
    @(negedge clk);
    chk(int'(mode), 5, "R7 mode restored");
    @(negedge clk);
    chk(int'(mode), 2, "R7 mode follows");

    // refused start during a sequence
    thr = 11;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(int'(err), 1, "R8 err set");
    wait_done();
    chk(int'(trim), 11, "R8 sequence unaffected");
    repeat (3) @(negedge clk);
    chk(int'(err), 1, "R8 err sticky");
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(int'(err), 0, "R8 err cleared");
    wait_done();

    // direct writes, idle and mid-search
    @(negedge clk); usr_wr = 1'b1; usr_trim = 5'd7;
    @(negedge clk); usr_wr = 1'b0;
    chk(int'(trim), 7, "R9 idle write");
    thr = 25;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (SETTLE + 1) @(negedge clk);
    usr_wr = 1'b1; usr_trim = 5'd3;
    @(negedge clk); usr_wr = 1'b0;
    chk(int'(trim), 3, "R9 write during search");
    wait_done();
    repeat (2) @(negedge clk);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule